// File: doc/BRIEF.md
# Vector Address Generation Unit

This unit builds a vector of memory addresses from two source vectors in one registered step. Each destination lane receives the matching base lane plus the matching offset lane scaled by 1, 2, 4 or 8. The offset is shifted left by 0 to 3 bits, and both the shift and the add wrap at the lane width. A 32-bit instruction word travels with the operands. The unit checks that the word is a member of the address-generation group and takes the lane mode, the scale and the three register numbers from fixed fields of the word.

There are four lane modes. Two are packed modes, with 32-bit or 64-bit lanes, in which base, offset and result share one width. The other two use 64-bit lanes but take only the low 32 bits of each offset lane, which are sign-extended or zero-extended to 64 bits before scaling. The result, the register numbers and a valid flag appear one clock after the word is presented. A word outside the group raises a one-cycle undefined-instruction flag in place of a result.

Top module: `vaddr_gen`

## Requirements
- R1: While rst_ni is low, out_valid_o and undef_o are 0 and result_o is all zeros.
- R2: A word is accepted when bits 31:24 equal 8'h04, bit 21 is 1 and bits 15:12 equal 4'hA. An accepted word with in_valid_i high gives out_valid_o high in the next cycle. In every other cycle out_valid_o is low.
- R3: With in_valid_i high and a word that is not accepted, undef_o is high in the next cycle only, out_valid_o stays low, and result_o keeps its previous value.
- R4: Mode field bits 23:22 = 2'b10 (packed 32) treats the vector as 32-bit lanes. Each lane i gives base + (offset << shift), modulo 2^32.
- R5: Mode 2'b11 (packed 64) treats the vector as 64-bit lanes. Each lane gives base + (offset << shift), modulo 2^64.
- R6: Mode 2'b00 (signed 32) uses 64-bit lanes. The low 32 bits of each offset lane are sign-extended to 64 bits before the shift. The upper 32 bits of the offset lane have no effect.
- R7: Mode 2'b01 (unsigned 32) uses 64-bit lanes. The low 32 bits of each offset lane are zero-extended to 64 bits before the shift. The upper 32 bits have no effect.
- R8: The shift amount is bits 11:10 of the word, so the offset is scaled by 1, 2, 4 or 8.
- R9: For an accepted word, the next cycle shows rd_o = bits 4:0, rn_o (base register) = bits 9:5 and rm_o (offset register) = bits 20:16.
- R10: result_o and the register numbers hold their values in every cycle that follows a cycle with no accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Word and operands present this cycle |
| insn_i | input | 32 | Instruction word |
| base_i | input | VLEN | Base vector |
| offs_i | input | VLEN | Offset vector |
| out_valid_o | output | 1 | result_o and register numbers updated |
| undef_o | output | 1 | Last presented word was not accepted |
| result_o | output | VLEN | Address vector |
| rd_o | output | 5 | Destination register number |
| rn_o | output | 5 | Base register number |
| rm_o | output | 5 | Offset register number |

## Verification
The assertions assume that insn_i, base_i and offs_i carry known values whenever in_valid_i is high. They also assume that in_valid_i itself is never unknown once reset is released. The bench drives every input from a defined value at all times and changes inputs only on the falling clock edge. It returns in_valid_i to 0 between beats, so the hold property and the single-cycle undefined pulse are observed in isolation.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;
  localparam logic [7:0] GRP_TOP = 8'h04;
  localparam logic [3:0] GRP_MID = 4'hA;

  typedef enum logic [1:0] {
    MODE_S32 = 2'b00,
    MODE_U32 = 2'b01,
    MODE_P32 = 2'b10,
    MODE_P64 = 2'b11
  } lane_mode_e;

  typedef struct packed {
    logic       hit;
    lane_mode_e mode;
    logic [1:0] shamt;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } dec_t;
endpackage

// File: rtl/vaddr_decode.sv
module vaddr_decode
  import vaddr_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.hit   = (insn_i[31:24] == GRP_TOP) && insn_i[21] && (insn_i[15:12] == GRP_MID);
    dec_o.mode  = lane_mode_e'(insn_i[23:22]);
    dec_o.shamt = insn_i[11:10];
    dec_o.rm    = insn_i[20:16];
    dec_o.rn    = insn_i[9:5];
    dec_o.rd    = insn_i[4:0];
  end
endmodule

// File: rtl/vaddr_lane.sv
module vaddr_lane
  import vaddr_pkg::*;
(
  input  logic [63:0] base_i,
  input  logic [63:0] offs_i,
  input  lane_mode_e  mode_i,
  input  logic [1:0]  shamt_i,
  output logic [63:0] sum_o
);
  logic [63:0] ext_off;
  logic [31:0] lo_sum, hi_sum;

  always_comb begin
    lo_sum = base_i[31:0]  + (offs_i[31:0]  << shamt_i);
    hi_sum = base_i[63:32] + (offs_i[63:32] << shamt_i);
    unique case (mode_i)
      MODE_S32: ext_off = {{32{offs_i[31]}}, offs_i[31:0]};
      MODE_U32: ext_off = {32'h0, offs_i[31:0]};
      default:  ext_off = offs_i;
    endcase
    if (mode_i == MODE_P32) sum_o = {hi_sum, lo_sum};
    else                    sum_o = base_i + (ext_off << shamt_i);
  end
endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen
  import vaddr_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] base_i,
  input  logic [VLEN-1:0] offs_i,
  output logic            out_valid_o,
  output logic            undef_o,
  output logic [VLEN-1:0] result_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rn_o,
  output logic [4:0]      rm_o
);
  localparam int unsigned NLANE = VLEN / 64;

  dec_t            dec;
  logic [VLEN-1:0] sum_d;

  vaddr_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    vaddr_lane u_lane (
      .base_i (base_i[l*64 +: 64]),
      .offs_i (offs_i[l*64 +: 64]),
      .mode_i (dec.mode),
      .shamt_i(dec.shamt),
      .sum_o  (sum_d[l*64 +: 64])
    );
  end

  logic take;
  assign take = in_valid_i && dec.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      undef_o     <= 1'b0;
      result_o    <= '0;
      rd_o        <= '0;
      rn_o        <= '0;
      rm_o        <= '0;
    end else begin
      out_valid_o <= take;
      undef_o     <= in_valid_i && !dec.hit;
      if (take) begin
        result_o <= sum_d;
        rd_o     <= dec.rd;
        rn_o     <= dec.rn;
        rm_o     <= dec.rm;
      end
    end
  end
endmodule

// File: rtl/vaddr_gen_chk.sv
module vaddr_gen_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [31:0]     insn_i,
  input logic [VLEN-1:0] base_i,
  input logic [VLEN-1:0] offs_i,
  input logic            out_valid_o,
  input logic            undef_o,
  input logic [VLEN-1:0] result_o,
  input logic [4:0]      rd_o,
  input logic [4:0]      rn_o,
  input logic [4:0]      rm_o
);
  logic hit;
  assign hit = (insn_i[31:24] == 8'h04) && insn_i[21] && (insn_i[15:12] == 4'hA);

  logic [63:0] p64_ref;
  assign p64_ref = base_i[63:0] + (offs_i[63:0] << insn_i[11:10]);

  assert_valid_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && hit |=> out_valid_o && !undef_o);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && !undef_o);

  assert_undef_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !hit |=> undef_o && !out_valid_o && $stable(result_o));

  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && undef_o));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && hit) |=> $stable(result_o) && $stable(rd_o) && $stable(rn_o) && $stable(rm_o));

  assert_regnums_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && hit |=> rd_o == $past(insn_i[4:0]) && rn_o == $past(insn_i[9:5])
                          && rm_o == $past(insn_i[20:16]));

  assert_p64_lane0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && hit && insn_i[23:22] == 2'b11 |=> result_o[63:0] == $past(p64_ref));
endmodule

bind vaddr_gen vaddr_gen_chk #(.VLEN(VLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .insn_i(insn_i),
  .base_i(base_i), .offs_i(offs_i), .out_valid_o(out_valid_o), .undef_o(undef_o),
  .result_o(result_o), .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o)
);

// File: tb/vaddr_gen_test.sv
`timescale 1ns/1ps
module vaddr_gen_test;
  localparam int unsigned VLEN = 256;
  localparam int unsigned NL = VLEN / 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] base_i = '0, offs_i = '0;
  logic            out_valid_o, undef_o;
  logic [VLEN-1:0] result_o;
  logic [4:0]      rd_o, rn_o, rm_o;

  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  vaddr_gen #(.VLEN(VLEN)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] md, input logic [1:0] sh,
                                     input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {8'h04, md, 1'b1, rm, 4'hA, sh, rn, rd};
  endfunction

  // arithmetic reference: scaling by multiplication
  function automatic logic [VLEN-1:0] model(input logic [1:0] md, input logic [1:0] sh,
                                            input logic [VLEN-1:0] b, input logic [VLEN-1:0] o);
    logic [VLEN-1:0] r;
    logic [63:0] scale, bb, oo, ext;
    logic [31:0] s32;
    scale = 64'd1 << sh;
    s32 = 32'd1 << sh;
    for (int l = 0; l < NL; l++) begin
      bb = b[l*64 +: 64];
      oo = o[l*64 +: 64];
      case (md)
        2'b10: begin
          r[l*64 +: 32]      = bb[31:0] + oo[31:0] * s32;
          r[l*64 + 32 +: 32] = bb[63:32] + oo[63:32] * s32;
        end
        2'b11: r[l*64 +: 64] = bb + oo * scale;
        2'b00: begin
          ext = 64'($signed(oo[31:0]));
          r[l*64 +: 64] = bb + ext * scale;
        end
        default: begin
          ext = 64'(oo[31:0]);
          r[l*64 +: 64] = bb + ext * scale;
        end
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] md);
    case (md)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic beat(input logic [31:0] w, input logic [VLEN-1:0] b, input logic [VLEN-1:0] o);
    @(negedge clk_i);
    in_valid_i = 1'b1; insn_i = w; base_i = b; offs_i = o;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic good(input logic [1:0] md, input logic [1:0] sh, input logic [VLEN-1:0] b, input logic [VLEN-1:0] o);
    logic [4:0] rm, rn, rd;
    logic [VLEN-1:0] exp, held;
    rm = 5'($urandom); rn = 5'($urandom); rd = 5'($urandom);
    exp = model(md, sh, b, o);
    beat(mk(md, sh, rm, rn, rd), b, o);
    chk(out_valid_o === 1'b1 && undef_o === 1'b0, "R2", VLEN'(out_valid_o), 1);
    chk(result_o === exp, $sformatf("%s R8 sh=%0d", req_of(md), sh), result_o, exp);
    chk(rd_o === rd && rn_o === rn && rm_o === rm, "R9",
        VLEN'({rd_o, rn_o, rm_o}), VLEN'({rd, rn, rm}));
    held = result_o;
    base_i = rnd(); offs_i = rnd();
    @(negedge clk_i);
    chk(out_valid_o === 1'b0 && result_o === held, "R10", result_o, held);
  endtask

  task automatic bad(input logic [31:0] w);
    logic [VLEN-1:0] held;
    held = result_o;
    beat(w, rnd(), rnd());
    chk(undef_o === 1'b1 && out_valid_o === 1'b0, "R3 flag", VLEN'({undef_o, out_valid_o}), VLEN'(2'b10));
    chk(result_o === held, "R3 hold", result_o, held);
    @(negedge clk_i);
    chk(undef_o === 1'b0, "R3 pulse", VLEN'(undef_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(out_valid_o === 1'b0 && undef_o === 1'b0 && result_o === '0, "R1", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 6; k++) good(2'(m), 2'(s), rnd(), rnd());
        good(2'(m), 2'(s), rnd(), '1);
        good(2'(m), 2'(s), '1, '1);
        good(2'(m), 2'(s), rnd(), '0);
        good(2'(m), 2'(s), rnd(), {NL{64'h0000_0000_8000_0000}});
        good(2'(m), 2'(s), rnd(), {NL{64'hFFFF_FFFF_7FFF_FFFF}});
      end
    end
    // upper offset halves must not matter in the 32-bit-offset modes
    for (int m = 0; m < 2; m++) begin
      logic [VLEN-1:0] b, o1, o2, r1;
      b = rnd(); o1 = rnd(); o2 = o1;
      for (int l = 0; l < NL; l++) o2[l*64 + 32 +: 32] = ~o1[l*64 + 32 +: 32];
      beat(mk(2'(m), 2'd3, 5'd1, 5'd2, 5'd3), b, o1);
      r1 = result_o;
      beat(mk(2'(m), 2'd3, 5'd1, 5'd2, 5'd3), b, o2);
      chk(result_o === r1, m == 0 ? "R6 upper ignored" : "R7 upper ignored", result_o, r1);
    end
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      w = mk(2'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      bad(w ^ (32'h1 << (24 + k)));
    end
    bad(mk(2'b11, 2'd1, 5'd4, 5'd5, 5'd6) & ~32'h0020_0000);
    for (int k = 0; k < 4; k++) bad(mk(2'b10, 2'd2, 5'd7, 5'd8, 5'd9) ^ (32'h1 << (12 + k)));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule